// File: doc/BRIEF.md
# Dual-Context Microcode Sequencer

This block sits next to a decoded-uop cache and walks a single-port microcode ROM for two hardware threads. When the cache side meets a complex instruction for a thread, it raises that thread's entry request with a ROM entry pointer. The sequencer loads the pointer into that thread's context, then reads consecutive ROM words for the thread, emitting each as a uop tagged with the thread number. The flow ends at the word that carries the end-of-flow mark; in the cycle that word appears at the output, a return pulse tells the cache side that the thread is back under its control.

Both threads may run flows at once, with independent pointers into the one shared ROM. A round-robin arbiter gives the ROM port to the threads in turn when both can issue, and to the single thread when only one can. Each thread context is a two-state machine: `CTX_IDLE` (transition `accept` on an entry request, to `CTX_RUN`) and `CTX_RUN` (transition `retire` on its own end-of-flow word, back to `CTX_IDLE`). The arbiter is a two-state machine, `ARB_FAVOR_T0` and `ARB_FAVOR_T1`, naming the thread that wins a tie; on every grant it moves (transition `rotate`) to favour the thread not just granted. The ROM read is registered, so a uop leaves the block one cycle after its read was granted.

Top module: `mseq_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `uop_valid_o`, `ret_o` and `ent_busy_o` are all zero.
- R2: An entry request for an idle thread is accepted at the clock edge; that thread's busy bit is 1 from the next cycle, and, if it is alone, its first uop appears at the output two cycles after the request edge.
- R3: The ROM word at address a holds uop ((a * 339) XOR 0x5A00) truncated to UOP_W bits, and carries the end mark when the low FLOW_W bits of a are all ones; a flow emits the words from its entry address upward, one address per read, up to and including the first end-marked word.
- R4: Every granted ROM read produces exactly one cycle of `uop_valid_o` one cycle later, with `uop_tid_o` giving the thread (0 or 1) and `uop_data_o` the word read; no uop appears without a grant.
- R5: Bit t of `ret_o` pulses in the same cycle as thread t's end-marked uop, at most one bit at a time, and thread t is idle (busy 0) in the next cycle.
- R6: An entry request for a thread whose busy bit is 1 (including its return cycle) is ignored: the running flow's addresses and length are unchanged.
- R7: When both threads can issue, ROM reads alternate between them every cycle; a tie goes to the thread not granted most recently, thread 0 first after reset.
- R8: A thread that is the only one able to issue is granted the ROM in every cycle until its end-marked word appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ent_req_i | input | 2 | Entry request, bit t for thread t |
| ent_ptr0_i | input | ADDR_W | Entry pointer for thread 0 |
| ent_ptr1_i | input | ADDR_W | Entry pointer for thread 1 |
| ent_busy_o | output | 2 | Bit t set while thread t is in a flow |
| uop_valid_o | output | 1 | Uop output strobe |
| uop_tid_o | output | 1 | Thread the output uop belongs to |
| uop_data_o | output | UOP_W | Uop read from the ROM |
| uop_last_o | output | 1 | Output uop is end-marked |
| ret_o | output | 2 | Return-to-cache pulse, bit t for thread t |

## Verification
The hardest situation to reach is the one where a thread's end-marked word is at the output while the other thread is still issuing, since the finishing thread must drop out of arbitration in that very cycle and the other must take every following slot. The bench sweeps every pair of entry pointers started together, plus a staggered sweep, so flows of every length from one to eight words end against every phase of the other thread. Refused requests are fired in the middle of flows and in the return cycle, and the outputs are compared each cycle against a reference model built from the requirements.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
    localparam int NUM_THR = 2;

    typedef enum logic {
        CTX_IDLE = 1'b0,
        CTX_RUN  = 1'b1
    } ctx_state_e;

    typedef enum logic {
        ARB_FAVOR_T0 = 1'b0,
        ARB_FAVOR_T1 = 1'b1
    } arb_state_e;
endpackage

// File: rtl/mseq_ctx.sv
module mseq_ctx
    import mseq_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ent_req,
    input  logic [ADDR_W-1:0] ent_ptr,
    input  logic              done,
    input  logic              grant,
    output logic              busy,
    output logic              elig,
    output logic [ADDR_W-1:0] ptr
);
    ctx_state_e state_q, state_d;
    logic       accept;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CTX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        unique case (state_q)
            CTX_IDLE: begin
                if (ent_req) begin
                    accept  = 1'b1;
                    state_d = CTX_RUN;
                end
            end
            CTX_RUN: begin
                if (done) state_d = CTX_IDLE;
            end
            default: state_d = CTX_IDLE;
        endcase
    end

    always_comb begin
        busy = (state_q == CTX_RUN);
        elig = (state_q == CTX_RUN) && !done;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      ptr <= '0;
        else if (accept) ptr <= ent_ptr;
        else if (grant)  ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/mseq_arb.sv
module mseq_arb
    import mseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] elig,
    output logic       gnt_vld,
    output logic       gnt_id
);
    arb_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARB_FAVOR_T0;
        else        state_q <= state_d;
    end

    always_comb begin
        gnt_vld = |elig;
        gnt_id  = 1'b0;
        unique case (elig)
            2'b00: gnt_id = 1'b0;
            2'b01: gnt_id = 1'b0;
            2'b10: gnt_id = 1'b1;
            2'b11: gnt_id = (state_q == ARB_FAVOR_T1);
            default: gnt_id = 1'b0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        if (gnt_vld) state_d = gnt_id ? ARB_FAVOR_T0 : ARB_FAVOR_T1;
    end
endmodule

// File: rtl/mseq_rom.sv
module mseq_rom #(
    parameter int ADDR_W = 6,
    parameter int UOP_W  = 16,
    parameter int FLOW_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              rd_tid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              q_vld,
    output logic              q_tid,
    output logic [UOP_W-1:0]  q_uop,
    output logic              q_last
);
    function automatic logic [UOP_W-1:0] word_of(input logic [ADDR_W-1:0] a);
        logic [31:0] t;
        t = (32'(a) * 32'd339) ^ 32'h5A00;
        return t[UOP_W-1:0];
    endfunction

    function automatic logic last_of(input logic [ADDR_W-1:0] a);
        return &a[FLOW_W-1:0];
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_vld  <= 1'b0;
            q_tid  <= 1'b0;
            q_uop  <= '0;
            q_last <= 1'b0;
        end else begin
            q_vld <= rd_en;
            if (rd_en) begin
                q_tid  <= rd_tid;
                q_uop  <= word_of(rd_addr);
                q_last <= last_of(rd_addr);
            end
        end
    end
endmodule

// File: rtl/mseq_top.sv
module mseq_top
    import mseq_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int UOP_W  = 16,
    parameter int FLOW_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        ent_req_i,
    input  logic [ADDR_W-1:0] ent_ptr0_i,
    input  logic [ADDR_W-1:0] ent_ptr1_i,
    output logic [1:0]        ent_busy_o,
    output logic              uop_valid_o,
    output logic              uop_tid_o,
    output logic [UOP_W-1:0]  uop_data_o,
    output logic              uop_last_o,
    output logic [1:0]        ret_o
);
    logic [ADDR_W-1:0] ent_ptr [NUM_THR];
    logic [ADDR_W-1:0] ptr     [NUM_THR];
    logic [1:0]        done;
    logic [1:0]        elig;
    logic [1:0]        grant;
    logic              gnt_vld;
    logic              gnt_id;
    logic              q_vld, q_tid, q_last;
    logic [UOP_W-1:0]  q_uop;
    logic [ADDR_W-1:0] ptr0, ptr1;

    assign ent_ptr[0] = ent_ptr0_i;
    assign ent_ptr[1] = ent_ptr1_i;

    for (genvar t = 0; t < NUM_THR; t++) begin : g_ctx
        assign done[t]  = q_vld && q_last && (q_tid == 1'(t));
        assign grant[t] = gnt_vld && (gnt_id == 1'(t));
        mseq_ctx #(.ADDR_W(ADDR_W)) u_ctx (
            .clk     (clk),
            .rst_n   (rst_n),
            .ent_req (ent_req_i[t]),
            .ent_ptr (ent_ptr[t]),
            .done    (done[t]),
            .grant   (grant[t]),
            .busy    (ent_busy_o[t]),
            .elig    (elig[t]),
            .ptr     (ptr[t])
        );
    end

    mseq_arb u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .elig    (elig),
        .gnt_vld (gnt_vld),
        .gnt_id  (gnt_id)
    );

    assign ptr0 = ptr[0];
    assign ptr1 = ptr[1];

    mseq_rom #(.ADDR_W(ADDR_W), .UOP_W(UOP_W), .FLOW_W(FLOW_W)) u_rom (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (gnt_vld),
        .rd_tid  (gnt_id),
        .rd_addr (gnt_id ? ptr1 : ptr0),
        .q_vld   (q_vld),
        .q_tid   (q_tid),
        .q_uop   (q_uop),
        .q_last  (q_last)
    );

    assign uop_valid_o = q_vld;
    assign uop_tid_o   = q_tid;
    assign uop_data_o  = q_uop;
    assign uop_last_o  = q_vld && q_last;
    assign ret_o       = done;
endmodule

// File: rtl/mseq_chk.sv
module mseq_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        ent_req,
    input logic [ADDR_W-1:0] ent_ptr0,
    input logic [1:0]        busy,
    input logic [1:0]        ret,
    input logic              uop_valid,
    input logic              uop_tid,
    input logic [1:0]        elig,
    input logic              gnt_vld,
    input logic              gnt_id,
    input logic [ADDR_W-1:0] ptr0,
    input logic [ADDR_W-1:0] ptr1
);
    p_ret_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ret));
    p_ret_tag0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ret[0] |-> uop_valid && !uop_tid);
    p_ret_tag1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ret[1] |-> uop_valid && uop_tid);
    p_idle_after_ret_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ret[0] |=> !busy[0]);
    p_issue_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld |=> uop_valid && (uop_tid == $past(gnt_id)));
    p_no_issue_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_vld |=> !uop_valid);
    p_solo_t0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (elig == 2'b01) |-> gnt_vld && !gnt_id);
    p_solo_t1_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (elig == 2'b10) |-> gnt_vld && gnt_id);
    p_alternate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (elig == 2'b11 && $past(elig) == 2'b11) |-> gnt_id != $past(gnt_id));
    p_refuse0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy[0] && ent_req[0] && !(gnt_vld && !gnt_id)) |=> ptr0 == $past(ptr0));
    p_refuse1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy[1] && ent_req[1] && !(gnt_vld && gnt_id)) |=> ptr1 == $past(ptr1));
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy[0] && ent_req[0]) |=> busy[0] && ptr0 == $past(ent_ptr0));
endmodule

bind mseq_top mseq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ent_req   (ent_req_i),
    .ent_ptr0  (ent_ptr0_i),
    .busy      (ent_busy_o),
    .ret       (ret_o),
    .uop_valid (uop_valid_o),
    .uop_tid   (uop_tid_o),
    .elig      (elig),
    .gnt_vld   (gnt_vld),
    .gnt_id    (gnt_id),
    .ptr0      (ptr0),
    .ptr1      (ptr1)
);

// File: tb/tb_mseq_top.sv
module tb_mseq_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 6;
    localparam int UOP_W  = 16;
    localparam int FLOW_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        ent_req = '0;
    logic [ADDR_W-1:0] ent_ptr0 = '0, ent_ptr1 = '0;
    logic [1:0]        busy, ret;
    logic              uvld, utid, ulast;
    logic [UOP_W-1:0]  udata;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    // reference model state
    logic              m_act [2];
    logic [ADDR_W-1:0] m_ptr [2];
    logic              m_ov, m_tid, m_fav;
    logic [ADDR_W-1:0] m_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    mseq_top #(.ADDR_W(ADDR_W), .UOP_W(UOP_W), .FLOW_W(FLOW_W)) dut (
        .clk(clk), .rst_n(rst_n), .ent_req_i(ent_req),
        .ent_ptr0_i(ent_ptr0), .ent_ptr1_i(ent_ptr1),
        .ent_busy_o(busy), .uop_valid_o(uvld), .uop_tid_o(utid),
        .uop_data_o(udata), .uop_last_o(ulast), .ret_o(ret)
    );

    function automatic logic [UOP_W-1:0] exp_uop(input logic [ADDR_W-1:0] a);
        int v;
        v = (int'(a) * 339) ^ 'h5A00;
        return v[UOP_W-1:0];
    endfunction

    function automatic logic exp_last(input logic [ADDR_W-1:0] a);
        return (int'(a) % (1 << FLOW_W)) == ((1 << FLOW_W) - 1);
    endfunction

    function automatic logic [1:0] exp_ret();
        logic [1:0] r;
        r = '0;
        if (m_ov && exp_last(m_addr)) r[m_tid] = 1'b1;
        return r;
    endfunction

    task automatic model_reset();
        m_act[0] = 0; m_act[1] = 0; m_ptr[0] = '0; m_ptr[1] = '0;
        m_ov = 0; m_tid = 0; m_fav = 0; m_addr = '0;
    endtask

    task automatic check_outputs();
        logic bad;
        logic [1:0] er;
        bad = 0;
        er = exp_ret();
        if (busy !== {m_act[1], m_act[0]}) begin
            bad = 1;
            $display("FAIL R2/R6 busy: got %b expected %b", busy, {m_act[1], m_act[0]});
        end
        if (uvld !== m_ov) begin
            bad = 1;
            $display("FAIL R4 valid: got %b expected %b", uvld, m_ov);
        end
        if (m_ov && utid !== m_tid) begin
            bad = 1;
            $display("FAIL R7/R8 tid: got %0d expected %0d", utid, m_tid);
        end
        if (m_ov && udata !== exp_uop(m_addr)) begin
            bad = 1;
            $display("FAIL R3 uop: got %h expected %h (addr %0d)", udata, exp_uop(m_addr), m_addr);
        end
        if (ret !== er || ulast !== (m_ov && exp_last(m_addr))) begin
            bad = 1;
            $display("FAIL R5 ret/last: got %b/%b expected %b/%b", ret, ulast, er, m_ov && exp_last(m_addr));
        end
        vectors++;
        if (bad) miscompares++;
    endtask

    task automatic step(input logic [1:0] req, input logic [ADDR_W-1:0] p0, input logic [ADDR_W-1:0] p1);
        logic [1:0] er, el;
        logic g, gv;
        @(negedge clk);
        check_outputs();
        ent_req = req; ent_ptr0 = p0; ent_ptr1 = p1;
        er = exp_ret();
        el[0] = m_act[0] && !er[0];
        el[1] = m_act[1] && !er[1];
        gv = |el;
        g  = (el == 2'b11) ? m_fav : el[1];
        m_ov = gv;
        if (gv) begin
            m_tid  = g;
            m_addr = m_ptr[g];
            m_ptr[g] = m_ptr[g] + 1'b1;
            m_fav = ~g;
        end
        for (int t = 0; t < 2; t++) begin
            if (er[t]) m_act[t] = 0;
            else if (!m_act[t] && req[t]) begin
                m_act[t] = 1;
                m_ptr[t] = (t == 0) ? p0 : p1;
            end
        end
        @(posedge clk);
    endtask

    task automatic drain();
        while (m_act[0] || m_act[1] || m_ov) step(2'b00, '0, '0);
        step(2'b00, '0, '0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        miscompares++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        model_reset();
        // R1: outputs quiet during reset
        repeat (3) begin
            @(negedge clk);
            check_outputs();
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        // R1: first cycle after reset
        step(2'b00, '0, '0);

        // R2 R3 R5 R8: every entry pointer, each thread alone
        for (int p = 0; p < (1 << ADDR_W); p++) begin
            step(2'b01, ADDR_W'(p), '0);
            drain();
        end
        for (int p = 0; p < (1 << ADDR_W); p++) begin
            step(2'b10, '0, ADDR_W'(p));
            drain();
        end

        // R7: every pointer pair started together
        for (int a = 0; a < (1 << ADDR_W); a++) begin
            for (int b = 0; b < (1 << ADDR_W); b++) begin
                step(2'b11, ADDR_W'(a), ADDR_W'(b));
                drain();
            end
        end

        // R7 R8: staggered starts, thread 1 then thread 0 a cycle later
        for (int a = 0; a < (1 << ADDR_W); a += 3) begin
            for (int b = 0; b < (1 << ADDR_W); b += 5) begin
                step(2'b10, '0, ADDR_W'(b));
                step(2'b01, ADDR_W'(a), '0);
                drain();
            end
        end

        // R6: requests while busy, including in the return cycle
        for (int a = 0; a < 8; a++) begin
            step(2'b11, ADDR_W'(a), ADDR_W'(8 + a));
            for (int k = 0; k < 12; k++) step(2'b11, ADDR_W'(40 + k), ADDR_W'(20 + k));
            drain();
        end

        finish_run();
    end
endmodule